// File: doc/BRIEF.md
# Register-Mapped 32-Bit Sequential Divider

This peripheral divides a 32-bit unsigned dividend by a 32-bit unsigned divisor under software control. Software loads both operands as 16-bit halves over a plain register bus, then writes the control register with the division-mode bit and the start bit set. The block retires two quotient bits per clock and so needs exactly sixteen clocks. When it finishes, the quotient replaces the dividend in operand register A and the remainder lands in result register C.

The start bit reads back as a busy flag and clears itself on completion. A one-cycle interrupt pulse marks the end of the operation unless the accumulate-mode bit is set. Operands and mode bits survive an operation, so a follow-up division needs only a new start write. Because A now holds the quotient, that follow-up divides the old quotient by the same divisor.

Top module: `seq_div_periph`

## Requirements
- R1: After reset every register address (0 to 6) reads 0 and `irq_o` is low.
- R2: Address 1 holds the low half and address 2 the high half of operand A (the dividend). Address 3 holds the low half and address 4 the high half of operand B (the divisor). The four halves can be written in any order and read back unchanged while idle.
- R3: A write to address 0 with bit 7 (division mode) and bit 0 (start) both 1 starts a division. Bit 0 reads 1 for the 16 cycles after the start edge and reads 0 from the 16th edge onward.
- R4: On completion, A holds floor(dividend/divisor) (low half at 1, high at 2) and C holds dividend mod divisor (low half at 5, high at 6).
- R5: `irq_o` is high for exactly one cycle, right after the completing edge, when control bit 6 (accumulate mode) is 0. When bit 6 is 1 there is no pulse.
- R6: A zero divisor yields quotient 0xFFFFFFFF and a remainder equal to the dividend.
- R7: While a division runs, writes to addresses 0 to 4 are ignored, and the result matches the operands present at the start.
- R8: A second start write with no operand writes divides the current A (the previous quotient) by the retained B.
- R9: A control write with bit 0 set but bit 7 clear starts nothing: bit 0 stays 0, no pulse occurs and A is unchanged.
- R10: Address 0 reads back bits 7 and 6 as last written while idle, and bit 0 as the busy flag. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable (with strobe) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The start write takes effect on its own clock edge. The busy bit is due one cycle later and stays set through fifteen more edges. The quotient, the remainder and the cleared busy bit all appear after the sixteenth edge, and the interrupt is high only in the cycle after that edge. The bench counts falling edges from the start edge and samples the busy bit after the fifteenth and sixteenth. It samples the interrupt after the sixteenth and seventeenth, and reads the results only after that. Reads are combinational, so every sample is taken a fraction of a cycle after a falling edge, well clear of the next rising edge.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned DATA_W   = 2 * HALF_W;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned STEP_BITS = 2;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_ACC_BIT   = 6;
  localparam int unsigned CTRL_DIV_BIT   = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_A_LO = 3'd1,
    REG_A_HI = 3'd2,
    REG_B_LO = 3'd3,
    REG_B_HI = 3'd4,
    REG_C_LO = 3'd5,
    REG_C_HI = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/div_stage.sv
// One restoring radix-2 step: shift in the next dividend bit, subtract if possible.
module div_stage #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    trial = {rem_i, quo_i[W-1]};
    diff  = trial - {1'b0, den_i};
    fits  = trial >= {1'b0, den_i};
    rem_o = fits ? diff[W-1:0] : trial[W-1:0];
    quo_o = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned W         = 32,
  parameter int unsigned STEP_BITS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CYCLES = W / STEP_BITS;
  localparam int unsigned CNT_W  = $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [W-1:0]     rem_q, quo_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  logic [W-1:0] rem_chain [STEP_BITS+1];
  logic [W-1:0] quo_chain [STEP_BITS+1];

  assign rem_chain[0] = rem_q;
  assign quo_chain[0] = quo_q;

  for (genvar k = 0; k < STEP_BITS; k++) begin : g_step
    div_stage #(.W(W)) i_stage (
      .rem_i (rem_chain[k]),
      .quo_i (quo_chain[k]),
      .den_i (den_q),
      .rem_o (rem_chain[k+1]),
      .quo_o (quo_chain[k+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      den_q  <= divisor_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q <= rem_chain[STEP_BITS];
      quo_q <= quo_chain[STEP_BITS];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign quot_o = quo_chain[STEP_BITS];
  assign rem_o  = rem_chain[STEP_BITS];
endmodule

// File: rtl/div_regbank.sv
module div_regbank
  import seq_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] quot_i,
  input  logic [DATA_W-1:0] rem_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic              start_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] a_q, b_q, c_q;
  logic              div_mode_q, acc_mode_q, irq_q;
  logic              wr_ok;

  assign wr_ok   = sel_i && we_i && !busy_i;
  assign start_o = wr_ok && (addr_i == REG_CTRL) &&
                   wdata_i[CTRL_START_BIT] && wdata_i[CTRL_DIV_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q        <= '0;
      b_q        <= '0;
      c_q        <= '0;
      div_mode_q <= 1'b0;
      acc_mode_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= done_i && !acc_mode_q;
      if (done_i) begin
        a_q <= quot_i;
        c_q <= rem_i;
      end else if (wr_ok) begin
        unique case (addr_i)
          REG_CTRL: begin
            div_mode_q <= wdata_i[CTRL_DIV_BIT];
            acc_mode_q <= wdata_i[CTRL_ACC_BIT];
          end
          REG_A_LO: a_q[HALF_W-1:0]      <= wdata_i;
          REG_A_HI: a_q[DATA_W-1:HALF_W] <= wdata_i;
          REG_B_LO: b_q[HALF_W-1:0]      <= wdata_i;
          REG_B_HI: b_q[DATA_W-1:HALF_W] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_DIV_BIT]   = div_mode_q;
        rdata_o[CTRL_ACC_BIT]   = acc_mode_q;
        rdata_o[CTRL_START_BIT] = busy_i;
      end
      REG_A_LO: rdata_o = a_q[HALF_W-1:0];
      REG_A_HI: rdata_o = a_q[DATA_W-1:HALF_W];
      REG_B_LO: rdata_o = b_q[HALF_W-1:0];
      REG_B_HI: rdata_o = b_q[DATA_W-1:HALF_W];
      REG_C_LO: rdata_o = c_q[HALF_W-1:0];
      REG_C_HI: rdata_o = c_q[DATA_W-1:HALF_W];
      default:  rdata_o = '0;
    endcase
  end

  assign a_o   = a_q;
  assign b_o   = b_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/seq_div_periph.sv
module seq_div_periph
  import seq_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] a_val, b_val, quot, rem;
  logic              start, busy, done;

  div_regbank i_regbank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (bus_sel_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .busy_i  (busy),
    .done_i  (done),
    .quot_i  (quot),
    .rem_i   (rem),
    .a_o     (a_val),
    .b_o     (b_val),
    .start_o (start),
    .irq_o   (irq_o)
  );

  div_core #(.W(DATA_W), .STEP_BITS(STEP_BITS)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .dividend_i (a_val),
    .divisor_i  (b_val),
    .busy_o     (busy),
    .done_o     (done),
    .quot_o     (quot),
    .rem_o      (rem)
  );
endmodule

// File: rtl/seq_div_chk.sv
module seq_div_chk
  import seq_div_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              irq_o,
  input logic [DATA_W-1:0] a_val,
  input logic [DATA_W-1:0] b_val,
  input logic [DATA_W-1:0] quot,
  input logic [DATA_W-1:0] rem
);
  localparam int unsigned CYCLES = DATA_W / STEP_BITS;
  logic [7:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy); // R3
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> run_len == 8'(CYCLES)); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !start); // R7
  AST_OPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> ($stable(a_val) && $stable(b_val))); // R7
  AST_QUOT_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && b_val != '0) |->
      (({32'b0, quot} * {32'b0, b_val}) + {32'b0, rem} == {32'b0, a_val}) && (rem < b_val)); // R4
  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && b_val == '0) |-> (quot == '1 && rem == a_val)); // R6
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(done)); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R5
endmodule

bind seq_div_periph seq_div_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .irq_o  (irq_o),
  .a_val  (a_val),
  .b_val  (b_val),
  .quot   (quot),
  .rem    (rem)
);

// File: tb/test_seq_div_periph.sv
`timescale 1ns/100ps
module test_seq_div_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          errors = 0, checks = 0, irq_count = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  seq_div_periph i_seq_div_periph (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) if (irq) irq_count++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic rd32(input logic [2:0] a_lo, output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] b);
    wr(3'd4, b[31:16]);
    wr(3'd1, a[15:0]);
    wr(3'd3, b[15:0]);
    wr(3'd2, a[31:16]);
  endtask

  // start and follow timing; returns at negedge after the 17th edge
  task automatic run_and_time(input bit acc, input string req);
    logic [15:0] c;
    wr(3'd0, acc ? 16'h00C1 : 16'h0081);
    repeat (15) @(negedge clk);
    rd_now(3'd0, c);
    chk(c[0] == 1'b1, "R3 busy after 15 edges", 32'(c), 32'h1);
    @(negedge clk);
    rd_now(3'd0, c);
    chk(c[0] == 1'b0, "R3 idle after 16 edges", 32'(c), 32'h0);
    chk(irq == !acc, {req, " R5 irq after completion"}, 32'(irq), 32'(!acc));
    @(negedge clk);
    chk(irq == 1'b0, "R5 irq one cycle", 32'(irq), 32'h0);
  endtask

  task automatic check_result(input logic [31:0] a, input logic [31:0] b, input string req);
    logic [31:0] q, r, eq, er;
    eq = (b == 0) ? 32'hFFFF_FFFF : a / b;
    er = (b == 0) ? a : a % b;
    rd32(3'd1, q);
    rd32(3'd5, r);
    chk(q == eq, {req, " quotient"}, q, eq);
    chk(r == er, {req, " remainder"}, r, er);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), d);
      chk(d == 16'h0, "R1 reset value", 32'(d), 32'h0);
    end
    chk(irq == 1'b0, "R1 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_operands();
    logic [31:0] v;
    logic [15:0] c;
    load(32'hA5A5_1234, 32'h0F0F_BEEF);
    rd32(3'd1, v);
    chk(v == 32'hA5A5_1234, "R2 operand A readback", v, 32'hA5A5_1234);
    rd32(3'd3, v);
    chk(v == 32'h0F0F_BEEF, "R2 operand B readback", v, 32'h0F0F_BEEF);
    wr(3'd0, 16'h00C0);
    rd(3'd0, c);
    chk(c == 16'h00C0, "R10 ctrl mode bits", 32'(c), 32'hC0);
    wr(3'd0, 16'h0084);
    rd(3'd0, c);
    chk(c == 16'h0080, "R10 ctrl unused bits", 32'(c), 32'h80);
  endtask

  task automatic t_divide(input logic [31:0] a, input logic [31:0] b, input bit acc, input string req);
    int n0;
    load(a, b);
    n0 = irq_count;
    run_and_time(acc, req);
    check_result(a, b, req);
    if (acc) chk(irq_count == n0, "R5 no irq in accumulate mode", 32'(irq_count - n0), 32'h0);
  endtask

  task automatic t_busy_writes();
    logic [15:0] c;
    load(32'd1_000_003, 32'd997);
    wr(3'd0, 16'h0081);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0040);
    wr(3'd0, 16'h0081);
    repeat (20) @(negedge clk);
    rd_now(3'd0, c);
    chk(c == 16'h0080, "R7 ctrl write ignored while busy", 32'(c), 32'h80);
    check_result(32'd1_000_003, 32'd997, "R7 operands frozen");
  endtask

  task automatic t_restart();
    logic [31:0] q1, q2, r2;
    load(32'd1000, 32'd7);
    run_and_time(1'b0, "R8 first");
    rd32(3'd1, q1);
    chk(q1 == 32'd142, "R8 first quotient", q1, 32'd142);
    run_and_time(1'b0, "R8 restart");
    rd32(3'd1, q2);
    rd32(3'd5, r2);
    chk(q2 == 32'd20, "R8 restart quotient", q2, 32'd20);
    chk(r2 == 32'd2, "R8 restart remainder", r2, 32'd2);
  endtask

  task automatic t_no_mode();
    logic [15:0] c;
    logic [31:0] v;
    int n0;
    load(32'h0000_0064, 32'h0000_0003);
    n0 = irq_count;
    wr(3'd0, 16'h0001);
    rd_now(3'd0, c);
    chk(c == 16'h0000, "R9 no start without mode", 32'(c), 32'h0);
    repeat (20) @(negedge clk);
    chk(irq_count == n0, "R9 no irq", 32'(irq_count - n0), 32'h0);
    rd32(3'd1, v);
    chk(v == 32'h64, "R9 A unchanged", v, 32'h64);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_operands();
    t_divide(32'd100, 32'd7, 1'b0, "R4 small");
    t_divide(32'hFFFF_FFFF, 32'd1, 1'b0, "R4 by one");
    t_divide(32'h1234_5678, 32'h0000_1234, 1'b0, "R4 mixed");
    t_divide(32'd5, 32'd9, 1'b0, "R4 zero quotient");
    t_divide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4 equal");
    t_divide(32'hDEAD_BEEF, 32'd0, 1'b0, "R6 divide by zero");
    t_divide(32'h8000_0001, 32'h0001_0000, 1'b1, "R5 accumulate");
    t_busy_writes();
    t_restart();
    t_no_mode();
    finish_run();
  end
endmodule